// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block sits in front of an SPI master engine and feeds it a prepared list of transfers with no processor help. Software fills a small table of transfer descriptors. Each descriptor holds the word to send, the chip-select number to use, the transfer length in bits, and the number of idle cycles to leave once the transfer ends. Software then names a first and a last table index and issues a start pulse. The sequencer hands each descriptor to the engine in turn. When the engine returns a received word, the sequencer stores it in the result slot that has the same index, so peripherals look to software like a block of memory.

In the default mode the walk stops after the last index and raises a completion flag. An interrupt follows that flag when it is enabled. In loop mode the sequencer goes back to the first index after the last one and keeps going until it is halted, which suits steady polling of a converter. A halt request lets the transfer in flight finish and then stops. The index currently being served is visible at all times. Writes to descriptors that lie inside the running window are refused and flagged, so a live loop can never send a half-updated entry.

Top module: `qseq_top`

## Requirements
- R1: A `start` pulse while idle latches `start_ptr`, `end_ptr` and `wrap_en`. The sequencer then serves indices in ascending order from the first index. For each entry it gives one single-cycle `eng_req` pulse, with `eng_tx`, `eng_cs` and `eng_len` taken from that entry's descriptor and `cur_ptr` equal to that entry's index.
- R2: When `start_ptr` is greater than `end_ptr`, the walk goes from index DEPTH-1 on to index 0 and continues up to `end_ptr`.
- R3: After the engine's `eng_done` cycle for an entry whose delay field is D, the next `eng_req` of the same run is raised exactly D+2 cycles later.
- R4: On `eng_done`, `eng_rx` is stored into the result slot whose index equals the entry being served. `res_data` shows the slot selected by `res_idx` in the same cycle. Slots that are not served keep their value.
- R5: Without loop mode, once the gap after the `end_ptr` entry has elapsed, `busy` falls, `done` is set and `cur_ptr` stays at `end_ptr`. `done` is cleared by the next accepted start. `irq` is high exactly when `done` and `irq_en` are both high.
- R6: With loop mode, the entry after `end_ptr` is `start_ptr` again. The sequence repeats until halted, and `done` never sets.
- R7: A `halt` pulse while busy lets the current transfer and its gap complete. After that no further `eng_req` is issued, `busy` falls, `done` stays low and `cur_ptr` keeps the last served index.
- R8: A descriptor write while busy is refused if the index lies inside the latched window from first to last index (circular), and `err` is then set. The flag stays set until the next accepted start. A write while busy to an index outside that window, and any write while idle, is accepted and leaves `err` unchanged.
- R9: After reset, `busy`, `done`, `irq`, `err` and `eng_req` are low, `cur_ptr` is 0, and all result slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_we | input | 1 | Descriptor write strobe |
| ent_idx | input | IW | Descriptor index to write |
| ent_tx | input | DW | Transmit word for the entry |
| ent_cs | input | CSW | Chip-select number for the entry |
| ent_len | input | LENW | Transfer length in bits |
| ent_dly | input | DLYW | Idle cycles after the transfer |
| res_idx | input | IW | Result slot to read |
| res_data | output | DW | Selected result slot contents |
| start | input | 1 | Begin a run (ignored while busy) |
| halt | input | 1 | Stop after the current transfer |
| wrap_en | input | 1 | Loop mode, sampled at start |
| irq_en | input | 1 | Interrupt enable |
| start_ptr | input | IW | First index of the run |
| end_ptr | input | IW | Last index of the run |
| busy | output | 1 | A run is active |
| done | output | 1 | Non-looping run completed |
| irq | output | 1 | Completion interrupt |
| err | output | 1 | A descriptor write was refused |
| cur_ptr | output | IW | Index being served or last served |
| eng_req | output | 1 | Single-cycle request to the engine |
| eng_tx | output | DW | Word to transmit |
| eng_cs | output | CSW | Chip-select number |
| eng_len | output | LENW | Bit length |
| eng_done | input | 1 | Engine transfer complete |
| eng_rx | input | DW | Word received by the engine |

## Verification
The bench builds the block with a 16-entry table, 16-bit words, 2-bit chip-select numbers, 5-bit lengths and 4-bit delays. The power-of-two depth lets a start index above the end index wrap through 15 to 0. Delays of 0 to 2 cycles keep the gap timing of every transfer countable. An engine model with fixed latency closes each transfer. Loop mode stays within a few dozen cycles, so a halt, a refused in-window write and an accepted out-of-window write can all be placed inside one live run.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  // circular membership test: idx lies in [lo..hi], wrapping when lo > hi
  function automatic logic in_window(input logic [31:0] idx,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    if (lo <= hi) return (idx >= lo) && (idx <= hi);
    else          return (idx >= lo) || (idx <= hi);
  endfunction

endpackage

// File: rtl/qseq_store.sv
module qseq_store #(
  parameter int DEPTH = 16,
  parameter int IW    = 4,
  parameter int DW    = 16,
  parameter int CSW   = 2,
  parameter int LENW  = 5,
  parameter int DLYW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_tx,
  input  logic [CSW-1:0]  wr_cs,
  input  logic [LENW-1:0] wr_len,
  input  logic [DLYW-1:0] wr_dly,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_tx,
  output logic [CSW-1:0]  rd_cs,
  output logic [LENW-1:0] rd_len,
  output logic [DLYW-1:0] rd_dly,
  input  logic            res_we,
  input  logic [IW-1:0]   res_widx,
  input  logic [DW-1:0]   res_wdata,
  input  logic [IW-1:0]   res_ridx,
  output logic [DW-1:0]   res_rdata
);

  logic [DW-1:0]   tx_a  [DEPTH];
  logic [CSW-1:0]  cs_a  [DEPTH];
  logic [LENW-1:0] len_a [DEPTH];
  logic [DLYW-1:0] dly_a [DEPTH];
  logic [DW-1:0]   res_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic            desc_en;
    logic            res_en;
    logic [DW-1:0]   tx_q;
    logic [CSW-1:0]  cs_q;
    logic [LENW-1:0] len_q;
    logic [DLYW-1:0] dly_q;
    logic [DW-1:0]   res_q;

    assign desc_en = wr_en  && (wr_idx   == IW'(g));
    assign res_en  = res_we && (res_widx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q  <= '0;
        cs_q  <= '0;
        len_q <= '0;
        dly_q <= '0;
      end else if (desc_en) begin
        tx_q  <= wr_tx;
        cs_q  <= wr_cs;
        len_q <= wr_len;
        dly_q <= wr_dly;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (res_en) res_q <= res_wdata;
    end

    assign tx_a[g]  = tx_q;
    assign cs_a[g]  = cs_q;
    assign len_a[g] = len_q;
    assign dly_a[g] = dly_q;
    assign res_a[g] = res_q;
  end

  assign rd_tx     = tx_a[rd_idx];
  assign rd_cs     = cs_a[rd_idx];
  assign rd_len    = len_a[rd_idx];
  assign rd_dly    = dly_a[rd_idx];
  assign res_rdata = res_a[res_ridx];

endmodule

// File: rtl/qseq_walker.sv
module qseq_walker
  import qseq_pkg::*;
#(
  parameter int IW   = 4,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            halt,
  input  logic            wrap_en,
  input  logic [IW-1:0]   start_ptr,
  input  logic [IW-1:0]   end_ptr,
  input  logic            eng_done,
  input  logic [DLYW-1:0] ent_dly,
  output logic            busy,
  output logic            done,
  output logic [IW-1:0]   cur,
  output logic [IW-1:0]   win_lo,
  output logic [IW-1:0]   win_hi,
  output logic            eng_req,
  output logic            res_we
);

  seq_state_e      state_q, state_d;
  logic [IW-1:0]   cur_q, cur_d, lo_q, lo_d, hi_q, hi_d;
  logic            wrap_q, wrap_d, halt_q, halt_d, done_q, done_d;
  logic [DLYW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    wrap_d  = wrap_q;
    halt_d  = halt_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    if (halt && (state_q != ST_IDLE)) halt_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          lo_d    = start_ptr;
          hi_d    = end_ptr;
          wrap_d  = wrap_en;
          cur_d   = start_ptr;
          halt_d  = 1'b0;
          done_d  = 1'b0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (eng_done) begin
          cnt_d   = ent_dly;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - DLYW'(1);
        end else if (halt_q) begin
          state_d = ST_IDLE;
        end else if (cur_q == hi_q) begin
          if (wrap_q) begin
            cur_d   = lo_q;
            state_d = ST_ISSUE;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          cur_d   = cur_q + IW'(1);
          state_d = ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      wrap_q  <= 1'b0;
      halt_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      wrap_q  <= wrap_d;
      halt_q  <= halt_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign cur     = cur_q;
  assign win_lo  = lo_q;
  assign win_hi  = hi_q;
  assign eng_req = (state_q == ST_ISSUE);
  assign res_we  = (state_q == ST_WAIT) && eng_done;

  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req); // R1
  AST_CUR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> in_window(32'(cur_q), 32'(lo_q), 32'(hi_q))); // R2
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R5
  AST_LOOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wrap_q) |=> !done_q); // R6
  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && (state_q == ST_GAP) && (cnt_q == '0)) |=> !eng_req); // R7

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CSW   = 2,
  parameter int LENW  = 5,
  parameter int DLYW  = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_we,
  input  logic [IW-1:0]   ent_idx,
  input  logic [DW-1:0]   ent_tx,
  input  logic [CSW-1:0]  ent_cs,
  input  logic [LENW-1:0] ent_len,
  input  logic [DLYW-1:0] ent_dly,
  input  logic [IW-1:0]   res_idx,
  output logic [DW-1:0]   res_data,
  input  logic            start,
  input  logic            halt,
  input  logic            wrap_en,
  input  logic            irq_en,
  input  logic [IW-1:0]   start_ptr,
  input  logic [IW-1:0]   end_ptr,
  output logic            busy,
  output logic            done,
  output logic            irq,
  output logic            err,
  output logic [IW-1:0]   cur_ptr,
  output logic            eng_req,
  output logic [DW-1:0]   eng_tx,
  output logic [CSW-1:0]  eng_cs,
  output logic [LENW-1:0] eng_len,
  input  logic            eng_done,
  input  logic [DW-1:0]   eng_rx
);

  logic [IW-1:0]   win_lo, win_hi;
  logic [DLYW-1:0] cur_dly;
  logic            res_we, hit_live, wr_ok;
  logic            err_q, err_d;

  assign hit_live = busy && in_window(32'(ent_idx), 32'(win_lo), 32'(win_hi));
  assign wr_ok    = ent_we && !hit_live;

  always_comb begin
    err_d = err_q;
    if (start && !busy)     err_d = 1'b0;
    if (ent_we && hit_live) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  qseq_store #(
    .DEPTH(DEPTH), .IW(IW), .DW(DW), .CSW(CSW), .LENW(LENW), .DLYW(DLYW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_idx(ent_idx), .wr_tx(ent_tx), .wr_cs(ent_cs),
    .wr_len(ent_len), .wr_dly(ent_dly),
    .rd_idx(cur_ptr), .rd_tx(eng_tx), .rd_cs(eng_cs), .rd_len(eng_len),
    .rd_dly(cur_dly),
    .res_we(res_we), .res_widx(cur_ptr), .res_wdata(eng_rx),
    .res_ridx(res_idx), .res_rdata(res_data)
  );

  qseq_walker #(.IW(IW), .DLYW(DLYW)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .start(start), .halt(halt), .wrap_en(wrap_en),
    .start_ptr(start_ptr), .end_ptr(end_ptr),
    .eng_done(eng_done), .ent_dly(cur_dly),
    .busy(busy), .done(done), .cur(cur_ptr),
    .win_lo(win_lo), .win_hi(win_hi),
    .eng_req(eng_req), .res_we(res_we)
  );

  assign err = err_q;
  assign irq = done && irq_en;

  AST_REFUSED_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && busy) |=> err_q); // R8

endmodule

// File: tb/tb_qseq_top.sv
module tb_qseq_top;

  localparam int DEPTH = 16;
  localparam int IW    = 4;
  localparam int DW    = 16;
  localparam int CSW   = 2;
  localparam int LENW  = 5;
  localparam int DLYW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_we = 1'b0;
  logic [IW-1:0] ent_idx = '0;
  logic [DW-1:0] ent_tx = '0;
  logic [CSW-1:0] ent_cs = '0;
  logic [LENW-1:0] ent_len = '0;
  logic [DLYW-1:0] ent_dly = '0;
  logic [IW-1:0] res_idx = '0;
  logic [DW-1:0] res_data;
  logic start = 1'b0, halt = 1'b0, wrap_en = 1'b0, irq_en = 1'b0;
  logic [IW-1:0] start_ptr = '0, end_ptr = '0;
  logic busy, done, irq, err;
  logic [IW-1:0] cur_ptr;
  logic eng_req;
  logic [DW-1:0] eng_tx;
  logic [CSW-1:0] eng_cs;
  logic [LENW-1:0] eng_len;
  logic eng_done = 1'b0;
  logic [DW-1:0] eng_rx = '0;

  qseq_top #(.DEPTH(DEPTH), .DW(DW), .CSW(CSW), .LENW(LENW), .DLYW(DLYW)) dut (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_idx(ent_idx), .ent_tx(ent_tx),
    .ent_cs(ent_cs), .ent_len(ent_len), .ent_dly(ent_dly), .res_idx(res_idx),
    .res_data(res_data), .start(start), .halt(halt), .wrap_en(wrap_en),
    .irq_en(irq_en), .start_ptr(start_ptr), .end_ptr(end_ptr), .busy(busy),
    .done(done), .irq(irq), .err(err), .cur_ptr(cur_ptr), .eng_req(eng_req),
    .eng_tx(eng_tx), .eng_cs(eng_cs), .eng_len(eng_len), .eng_done(eng_done),
    .eng_rx(eng_rx)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [IW-1:0]   idx;
    logic [DW-1:0]   tx;
    logic [CSW-1:0]  cs;
    logic [LENW-1:0] len;
  } exp_t;

  exp_t exp_q[$];
  logic [DW-1:0]   m_tx  [DEPTH];
  logic [CSW-1:0]  m_cs  [DEPTH];
  logic [LENW-1:0] m_len [DEPTH];
  logic [DLYW-1:0] m_dly [DEPTH];

  int tests = 0, fails = 0, cyc = 0, issue_cnt = 0;
  int last_done_cyc = 0, last_dly = 0;
  bit first_in_run = 1'b1, finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int i);
    exp_t e;
    e.idx = IW'(i);
    e.tx  = m_tx[i];
    e.cs  = m_cs[i];
    e.len = m_len[i];
    exp_q.push_back(e);
  endtask

  task automatic wr_ent(input int i, input logic [DW-1:0] tx, input logic [CSW-1:0] cs,
                        input logic [LENW-1:0] len, input logic [DLYW-1:0] dly,
                        input bit accept);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = IW'(i); ent_tx = tx; ent_cs = cs; ent_len = len; ent_dly = dly;
    @(negedge clk);
    ent_we = 1'b0;
    if (accept) begin
      m_tx[i] = tx; m_cs[i] = cs; m_len[i] = len; m_dly[i] = dly;
    end
  endtask

  task automatic kick(input int s, input int e, input bit wrap);
    @(negedge clk);
    first_in_run = 1'b1;
    start_ptr = IW'(s); end_ptr = IW'(e); wrap_en = wrap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_res(input int i, output logic [DW-1:0] v);
    @(negedge clk);
    res_idx = IW'(i);
    #1 v = res_data;
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req) begin
        exp_t e;
        logic [DW-1:0] rx;
        issue_cnt++;
        if (!first_in_run)
          chk((cyc - last_done_cyc) == last_dly + 2, "R3", "request spacing",
              cyc - last_done_cyc, last_dly + 2);
        first_in_run = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected request at index", cur_ptr, 0);
        end else begin
          e = exp_q.pop_front();
          chk({cur_ptr, eng_tx, eng_cs, eng_len} == e, "R1", "issued entry",
              {cur_ptr, eng_tx, eng_cs, eng_len}, e);
        end
        last_dly = int'(m_dly[cur_ptr]);
        rx = ~eng_tx;
        repeat (2) @(negedge clk);
        eng_done = 1'b1; eng_rx = rx; last_done_cyc = cyc;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk({busy, done, irq, err, eng_req} == 5'b0, "R9", "status after reset",
        {busy, done, irq, err, eng_req}, 0);
    chk(cur_ptr == 0, "R9", "cur_ptr after reset", cur_ptr, 0);
    read_res(0, v);  chk(v == 0, "R9", "slot 0 after reset", v, 0);
    read_res(15, v); chk(v == 0, "R9", "slot 15 after reset", v, 0);

    for (int i = 0; i < DEPTH; i++)
      wr_ent(i, DW'(i * 16'h0913 + 16'h0A5C), CSW'(i % 4), LENW'(8 + i), DLYW'(i % 3), 1'b1);

    // R1 R3 R4 R5: plain run 2..5
    irq_en = 1'b1;
    for (int i = 2; i <= 5; i++) push_exp(i);
    kick(2, 5, 1'b0);
    wait_idle();
    chk(exp_q.size() == 0, "R1", "entries left unserved", exp_q.size(), 0);
    chk(done == 1'b1, "R5", "done after run", done, 1);
    chk(irq == 1'b1, "R5", "irq with enable", irq, 1);
    chk(cur_ptr == 5, "R5", "cur_ptr at end", cur_ptr, 5);
    for (int i = 2; i <= 5; i++) begin
      read_res(i, v);
      chk(v == ~m_tx[i], "R4", "result slot", v, ~m_tx[i]);
    end
    read_res(6, v); chk(v == 0, "R4", "unserved slot 6", v, 0);

    // R2: circular window 14..1, irq masked
    irq_en = 1'b0;
    push_exp(14); push_exp(15); push_exp(0); push_exp(1);
    kick(14, 1, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done cleared by start", done, 0);
    wait_idle();
    chk(exp_q.size() == 0, "R2", "wrapped walk incomplete", exp_q.size(), 0);
    chk(done == 1'b1 && irq == 1'b0, "R5", "done set irq masked", {done, irq}, 2'b10);
    irq_en = 1'b1;
    #1 chk(irq == 1'b1, "R5", "irq follows enable", irq, 1);
    read_res(15, v); chk(v == ~m_tx[15], "R4", "slot 15", v, ~m_tx[15]);
    read_res(0, v);  chk(v == ~m_tx[0], "R4", "slot 0", v, ~m_tx[0]);

    // R6 R7 R8: loop 3..4, live writes, then halt
    issue_cnt = 0;
    push_exp(3); push_exp(4); push_exp(3); push_exp(4); push_exp(3);
    kick(3, 4, 1'b1);
    while (issue_cnt < 1) @(negedge clk);
    wr_ent(9, 16'hBEEF, 2'd3, 5'd12, 4'd1, 1'b1);
    chk(err == 1'b0, "R8", "out-of-window write flag", err, 0);
    wr_ent(4, 16'hDEAD, 2'd1, 5'd3, 4'd0, 1'b0);
    chk(err == 1'b1, "R8", "in-window write flag", err, 1);
    while (issue_cnt < 5) @(negedge clk);
    chk(done == 1'b0, "R6", "done during loop", done, 0);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    wait_idle();
    repeat (6) @(negedge clk);
    chk(issue_cnt == 5, "R7", "requests after halt", issue_cnt, 5);
    chk(busy == 1'b0 && done == 1'b0, "R7", "stopped without done", {busy, done}, 0);
    chk(cur_ptr == 3, "R7", "cur_ptr after halt", cur_ptr, 3);
    chk(err == 1'b1, "R8", "flag sticky", err, 1);
    read_res(4, v); chk(v == ~m_tx[4], "R4", "slot 4 from loop", v, ~m_tx[4]);

    // R8: accepted write used, flag cleared by start
    push_exp(9);
    kick(9, 9, 1'b0);
    chk(err == 1'b0, "R8", "flag cleared at start", err, 0);
    wait_idle();
    chk(done == 1'b1, "R5", "single-entry run done", done, 1);
    read_res(9, v); chk(v == ~16'hBEEF, "R4", "slot 9", v, ~16'hBEEF);

    // R8: idle write accepted
    wr_ent(4, 16'h1234, 2'd2, 5'd7, 4'd0, 1'b1);
    chk(err == 1'b0, "R8", "idle write flag", err, 0);
    push_exp(4);
    kick(4, 4, 1'b0);
    wait_idle();
    read_res(4, v); chk(v == ~16'h1234, "R8", "idle write took effect", v, ~16'h1234);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule